// File: doc/BRIEF.md
# (1,7) Run-Length-Limited Encoder, Rate 2/3

This block is a streaming channel encoder for a magnetic recording write path. It accepts NRZ user data two bits at a time and turns each dibit into a three-bit code word. The code bits leave one per beat, so the output bit rate is one and a half times the input bit rate. The resulting stream never has two adjacent ones, and never has more than seven zeros between two ones. A code word cannot be chosen from the current dibit alone. When a word ending in 1 would be followed by a word starting with 1, the two dibits are encoded together as a six-bit substitute. The encoder therefore holds one dibit back and looks at the next one on the input before it commits. A build parameter selects a serial front end that takes one data bit per beat and pairs the bits itself.

Both data interfaces are valid/ready. An input beat is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` depends only on the internal state and `out_ready`, never on `in_valid` or `in_data`. A code bit is taken on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the output stays frozen. `in_last` marks the final beat of a record. The matching final code bit carries `out_last`. If the record ends on a dibit that needs a look-ahead, the block supplies zero data as padding, so the record still ends in a legal code word.

Top module: `rll17_encoder`

## Requirements
- R1: Dibit 01 encodes as 100 and dibit 11 encodes as 010, with no wait for the next dibit. The first data bit is `in_data[1]`, and the first code bit sent is the leftmost bit of each word.
- R2: Dibit 00 encodes as 101 and dibit 10 as 001 when the next dibit of the record is 10 or 11.
- R3: When dibit 00 or 10 is followed by 00 or 01, both dibits together produce six bits: 00,00 gives 101000; 00,01 gives 100000; 10,00 gives 001000; 10,01 gives 010000.
- R4: If a record ends on 00 or 10, a padding dibit 00 completes a R3 substitution. `out_last` is high on the final code bit of the record and on no other bit.
- R5: The output stream never carries two consecutive ones.
- R6: Within a record, no more than seven zeros ever appear in a row on the output.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_bit` and `out_last` hold their values into the next cycle.
- R8: Whenever `out_valid` is low, `in_ready` is high.
- R9: After reset, `out_valid` is low and `in_ready` is high.
- R10: With `SERIAL_IN` set, consecutive input bits pair up, the first becoming the high bit of the dibit. A record with an odd number of bits gets a 0 as the second bit of its final dibit.
- R11: Decoding the output with the inverse of R1 to R3 gives back the input dibits of each record, followed by at most one padding 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat offered |
| in_data | input | IN_W (2, or 1 when SERIAL_IN) | Data dibit (bit 1 first) or single data bit |
| in_last | input | 1 | Final beat of a record |
| in_ready | output | 1 | Encoder takes the offered beat |
| out_valid | output | 1 | Code bit offered |
| out_bit | output | 1 | Current code bit |
| out_last | output | 1 | Final code bit of a record |
| out_ready | input | 1 | Sink takes the code bit |

## Verification
Directed records of only 01 and 11 show that words are emitted without look-ahead. Records with 00 or 10 followed by 10 or 11 separate a plain word from a substitution. A record holding all four substitution pairs shows that each pair consumes both dibits. Records ending on each kind of dibit separate zero padding from a plain final word. A long zero run and a random stream under random output stalls exercise the run-length bounds, the output hold and round-trip decoding. A separate instance in serial mode with an odd bit count shows the bit pairing and the padding bit.

// File: rtl/rll17_pkg.sv
package rll17_pkg;
  localparam int DIBIT_W = 2;
  localparam int CODE_W  = 3;
  localparam int PAIR_W  = 2 * CODE_W;
  localparam int LEN_W   = $clog2(PAIR_W + 1);

  typedef logic [DIBIT_W-1:0] dibit_t;
  typedef logic [CODE_W-1:0]  code_t;

  // plain word for one dibit
  function automatic code_t base_code(input dibit_t d);
    code_t c;
    case (d)
      2'b00:   c = 3'b101;
      2'b01:   c = 3'b100;
      2'b10:   c = 3'b001;
      default: c = 3'b010;
    endcase
    return c;
  endfunction

  // word whose last bit is 1
  function automatic logic tail_is_one(input dibit_t d);
    return !d[0];
  endfunction

  // word whose first bit is 1
  function automatic logic head_is_one(input dibit_t d);
    return !d[1];
  endfunction

  // first half of a six-bit substitute; second half is all zeros
  function automatic code_t merged_head(input dibit_t cur, input dibit_t nxt);
    return base_code({cur[1], nxt[0]});
  endfunction
endpackage

// File: rtl/rll17_in_front.sv
module rll17_in_front
  import rll17_pkg::*;
#(
  parameter bit SERIAL_IN = 1'b0,
  parameter int IN_W      = SERIAL_IN ? 1 : DIBIT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_data,
  input  logic            in_last,
  output logic            in_ready,
  output logic            dib_valid,
  output dibit_t          dib_data,
  output logic            dib_last,
  input  logic            dib_ready
);

  generate
    if (SERIAL_IN) begin : g_serial
      logic   half_v;
      logic   half_b;
      logic   pair_v;
      logic   pair_last;
      dibit_t pair_d;
      logic   bit_fire;

      assign in_ready = !pair_v || dib_ready;
      assign bit_fire = in_valid && in_ready;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          half_v    <= 1'b0;
          half_b    <= 1'b0;
          pair_v    <= 1'b0;
          pair_d    <= '0;
          pair_last <= 1'b0;
        end else begin
          if (pair_v && dib_ready) pair_v <= 1'b0;
          if (bit_fire) begin
            if (half_v) begin
              pair_v    <= 1'b1;
              pair_d    <= {half_b, in_data[0]};
              pair_last <= in_last;
              half_v    <= 1'b0;
            end else if (in_last) begin
              pair_v    <= 1'b1;
              pair_d    <= {in_data[0], 1'b0};
              pair_last <= 1'b1;
            end else begin
              half_v <= 1'b1;
              half_b <= in_data[0];
            end
          end
        end
      end

      assign dib_valid = pair_v;
      assign dib_data  = pair_d;
      assign dib_last  = pair_last;
    end else begin : g_dibit
      assign dib_valid = in_valid;
      assign dib_data  = dibit_t'(in_data);
      assign dib_last  = in_last;
      assign in_ready  = dib_ready;
    end
  endgenerate

endmodule

// File: rtl/rll17_word_sel.sv
module rll17_word_sel
  import rll17_pkg::*;
(
  input  dibit_t            cur,
  input  logic              cur_last,
  input  logic              nxt_valid,
  input  dibit_t            nxt,
  input  logic              nxt_last,
  output logic              decided,
  output logic [PAIR_W-1:0] word,
  output logic [LEN_W-1:0]  len,
  output logic              take_next,
  output logic              word_last
);

  localparam code_t ZERO_W = '0;

  always_comb begin
    decided   = 1'b1;
    take_next = 1'b0;
    word      = {base_code(cur), ZERO_W};
    len       = LEN_W'(CODE_W);
    word_last = cur_last;
    if (tail_is_one(cur)) begin
      if (cur_last) begin
        // record ends: pad with dibit 00, which always starts with 1
        word      = {merged_head(cur, dibit_t'(0)), ZERO_W};
        len       = LEN_W'(PAIR_W);
        word_last = 1'b1;
      end else if (!nxt_valid) begin
        decided = 1'b0;
      end else if (head_is_one(nxt)) begin
        word      = {merged_head(cur, nxt), ZERO_W};
        len       = LEN_W'(PAIR_W);
        take_next = 1'b1;
        word_last = nxt_last;
      end
    end
  end

endmodule

// File: rtl/rll17_serializer.sv
module rll17_serializer
  import rll17_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PAIR_W-1:0] word,
  input  logic [LEN_W-1:0]  len,
  input  logic              word_last,
  output logic              can_load,
  output logic              out_valid,
  output logic              out_bit,
  output logic              out_last,
  input  logic              out_ready
);

  logic [PAIR_W-1:0] sh;
  logic [LEN_W-1:0]  cnt;
  logic              last_q;
  logic              on_final;

  assign on_final  = (cnt == LEN_W'(1));
  assign out_valid = (cnt != '0);
  assign out_bit   = sh[PAIR_W-1];
  assign out_last  = last_q && on_final;
  assign can_load  = (cnt == '0) || (on_final && out_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh     <= '0;
      cnt    <= '0;
      last_q <= 1'b0;
    end else if (load) begin
      sh     <= word;
      cnt    <= len;
      last_q <= word_last;
    end else if (out_valid && out_ready) begin
      sh  <= {sh[PAIR_W-2:0], 1'b0};
      cnt <= cnt - LEN_W'(1);
    end
  end

endmodule

// File: rtl/rll17_encoder.sv
module rll17_encoder
  import rll17_pkg::*;
#(
  parameter bit SERIAL_IN = 1'b0,
  localparam int IN_W     = SERIAL_IN ? 1 : DIBIT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_data,
  input  logic            in_last,
  output logic            in_ready,
  output logic            out_valid,
  output logic            out_bit,
  output logic            out_last,
  input  logic            out_ready
);

  logic   dib_valid;
  dibit_t dib_data;
  logic   dib_last;
  logic   dib_ready;
  logic   dib_fire;

  logic   hold_v;
  dibit_t hold_d;
  logic   hold_last;
  logic   hold_fire;

  logic              sel_decided;
  logic [PAIR_W-1:0] sel_word;
  logic [LEN_W-1:0]  sel_len;
  logic              sel_take;
  logic              sel_last;
  logic              can_load;

  rll17_in_front #(.SERIAL_IN(SERIAL_IN), .IN_W(IN_W)) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .dib_valid (dib_valid),
    .dib_data  (dib_data),
    .dib_last  (dib_last),
    .dib_ready (dib_ready)
  );

  rll17_word_sel u_sel (
    .cur       (hold_d),
    .cur_last  (hold_last),
    .nxt_valid (dib_valid),
    .nxt       (dib_data),
    .nxt_last  (dib_last),
    .decided   (sel_decided),
    .word      (sel_word),
    .len       (sel_len),
    .take_next (sel_take),
    .word_last (sel_last)
  );

  // a dibit may enter whenever the hold slot is free or is about to empty
  assign dib_ready = !hold_v || can_load;
  assign dib_fire  = dib_valid && dib_ready;
  assign hold_fire = hold_v && sel_decided && can_load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v    <= 1'b0;
      hold_d    <= '0;
      hold_last <= 1'b0;
    end else if (hold_fire) begin
      if (dib_fire && !sel_take) begin
        hold_d    <= dib_data;
        hold_last <= dib_last;
      end else begin
        hold_v <= 1'b0;
      end
    end else if (dib_fire) begin
      hold_v    <= 1'b1;
      hold_d    <= dib_data;
      hold_last <= dib_last;
    end
  end

  rll17_serializer u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (hold_fire),
    .word      (sel_word),
    .len       (sel_len),
    .word_last (sel_last),
    .can_load  (can_load),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .out_last  (out_last),
    .out_ready (out_ready)
  );

endmodule

// File: rtl/rll17_encoder_chk.sv
module rll17_encoder_chk (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit,
  input logic out_last
);

  logic       prev_one;
  logic [3:0] zrun;
  logic       take;

  assign take = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_one <= 1'b0;
      zrun     <= '0;
    end else if (take) begin
      prev_one <= out_bit;
      if (out_last || out_bit) zrun <= '0;
      else if (zrun != 4'hF)   zrun <= zrun + 4'd1;
    end
  end

  // R5
  d_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && out_bit) |-> !prev_one);

  // R6
  k_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zrun <= 4'd7);

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_last)));

  // R8
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R4
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

endmodule

bind rll17_encoder rll17_encoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_bit   (out_bit),
  .out_last  (out_last)
);

// File: tb/test_rll17_encoder.sv
module test_rll17_encoder;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic       in_valid, in_last, in_ready;
  logic [1:0] in_data;
  logic       out_valid, out_bit, out_last, out_ready;

  logic       s_in_valid, s_in_last, s_in_ready;
  logic [0:0] s_in_data;
  logic       s_out_valid, s_out_bit, s_out_last, s_out_ready;

  rll17_encoder i_rll17_encoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .out_valid(out_valid),
    .out_bit(out_bit), .out_last(out_last), .out_ready(out_ready)
  );

  rll17_encoder #(.SERIAL_IN(1'b1)) i_rll17_encoder_ser (
    .clk(clk), .rst_n(rst_n), .in_valid(s_in_valid), .in_data(s_in_data),
    .in_last(s_in_last), .in_ready(s_in_ready), .out_valid(s_out_valid),
    .out_bit(s_out_bit), .out_last(s_out_last), .out_ready(s_out_ready)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  logic [1:0] stim [0:255];
  int         stim_n;
  logic       cap  [0:1023];
  int         cap_n;
  int         last_at;
  logic       got_last;
  logic       bp_en;
  logic       sel_ser;
  logic       expb [0:1023];
  int         exp_n;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  // output monitor: drives ready at the falling edge, samples 1 ns later
  initial begin
    out_ready   = 1'b1;
    s_out_ready = 1'b1;
    cap_n = 0; got_last = 1'b0; last_at = -1; bp_en = 1'b0; sel_ser = 1'b0;
    forever begin
      @(negedge clk);
      out_ready = bp_en ? ($urandom_range(0, 2) != 0) : 1'b1;
      #1;
      if (rst_n === 1'b1) begin
        if (!sel_ser && out_valid && out_ready && cap_n < 1024) begin
          cap[cap_n] = out_bit;
          if (out_last) begin last_at = cap_n; got_last = 1'b1; end
          cap_n++;
        end else if (sel_ser && s_out_valid && s_out_ready && cap_n < 1024) begin
          cap[cap_n] = s_out_bit;
          if (s_out_last) begin last_at = cap_n; got_last = 1'b1; end
          cap_n++;
        end
      end
    end
  end

  task automatic send_dibit(input logic [1:0] d, input bit last);
    bit r;
    in_valid = 1'b1; in_data = d; in_last = last;
    do begin #1; r = in_ready; @(negedge clk); end while (!r);
    in_valid = 1'b0;
  endtask

  task automatic send_bit(input logic b, input bit last);
    bit r;
    s_in_valid = 1'b1; s_in_data = b; s_in_last = last;
    do begin #1; r = s_in_ready; @(negedge clk); end while (!r);
    s_in_valid = 1'b0;
  endtask

  function automatic logic [2:0] ref_word(input logic [1:0] d);
    case (d)
      2'b00: return 3'b101;
      2'b01: return 3'b100;
      2'b10: return 3'b001;
      default: return 3'b010;
    endcase
  endfunction

  function automatic logic [5:0] ref_pair(input logic [1:0] c, input logic [1:0] n);
    case ({c, n})
      4'b0000: return 6'b101000;
      4'b0001: return 6'b100000;
      4'b1000: return 6'b001000;
      default: return 6'b010000;
    endcase
  endfunction

  task automatic build_expected;
    int i = 0;
    exp_n = 0;
    while (i < stim_n) begin
      logic [1:0] c = stim[i];
      logic [1:0] n = (i + 1 < stim_n) ? stim[i+1] : 2'b00;
      if ((c == 2'b00 || c == 2'b10) && (n == 2'b00 || n == 2'b01)) begin
        logic [5:0] w6 = ref_pair(c, n);
        for (int b = 5; b >= 0; b--) begin expb[exp_n] = w6[b]; exp_n++; end
        i += 2;
      end else begin
        logic [2:0] w3 = ref_word(c);
        for (int b = 2; b >= 0; b--) begin expb[exp_n] = w3[b]; exp_n++; end
        i += 1;
      end
    end
  endtask

  task automatic check_record(input string tag);
    int bad = -1;
    int adj = 0;
    int run = 0;
    int maxrun = 0;
    int seen_one = 0;
    int p = 0;
    int k = 0;
    int dec_bad = 0;
    logic [1:0] dec [0:511];
    build_expected();
    chk(cap_n == exp_n, tag, "code bit count", cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++)
      if (bad < 0 && cap[i] !== expb[i]) bad = i;
    chk(bad < 0, tag, "first wrong code bit index", bad, -1);
    chk(last_at == exp_n - 1, "R4", "out_last position", last_at, exp_n - 1);
    for (int i = 0; i < cap_n; i++) begin
      if (cap[i]) begin
        if (i > 0 && cap[i-1]) adj++;
        if (seen_one != 0 && run > maxrun) maxrun = run;
        seen_one = 1; run = 0;
      end else run++;
    end
    chk(adj == 0, "R5", "adjacent ones", adj, 0);
    chk(maxrun <= 7, "R6", "longest zero run", maxrun, 7);
    while (p + 3 <= cap_n && k < 510) begin
      logic [2:0] w = {cap[p], cap[p+1], cap[p+2]};
      if (p + 6 <= cap_n && {cap[p+3], cap[p+4], cap[p+5]} == 3'b000) begin
        case (w)
          3'b101: begin dec[k] = 2'b00; dec[k+1] = 2'b00; end
          3'b100: begin dec[k] = 2'b00; dec[k+1] = 2'b01; end
          3'b001: begin dec[k] = 2'b10; dec[k+1] = 2'b00; end
          3'b010: begin dec[k] = 2'b10; dec[k+1] = 2'b01; end
          default: dec_bad++;
        endcase
        k += 2; p += 6;
      end else begin
        case (w)
          3'b101: dec[k] = 2'b00;
          3'b100: dec[k] = 2'b01;
          3'b001: dec[k] = 2'b10;
          3'b010: dec[k] = 2'b11;
          default: dec_bad++;
        endcase
        k += 1; p += 3;
      end
    end
    if (k != stim_n && k != stim_n + 1) dec_bad++;
    for (int i = 0; i < stim_n && i < k; i++) if (dec[i] !== stim[i]) dec_bad++;
    if (k == stim_n + 1 && dec[stim_n] !== 2'b00) dec_bad++;
    chk(dec_bad == 0, "R11", "round-trip decode mismatches", dec_bad, 0);
  endtask

  task automatic run_main(input string tag, input bit bp);
    cap_n = 0; got_last = 1'b0; last_at = -1; sel_ser = 1'b0; bp_en = bp;
    for (int i = 0; i < stim_n; i++) send_dibit(stim[i], i == stim_n - 1);
    while (!got_last) @(negedge clk);
    bp_en = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready && !out_valid, "R8", "ready once drained", int'(in_ready), 1);
    @(negedge clk);
    check_record(tag);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_last = 1'b0;
    s_in_valid = 1'b0; s_in_data = '0; s_in_last = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R9", "in_ready after reset", int'(in_ready), 1);
    @(negedge clk);
  endtask

  task automatic t_plain_words;   // R1
    stim[0] = 2'b01; stim[1] = 2'b11; stim[2] = 2'b11; stim[3] = 2'b01;
    stim_n = 4;
    run_main("R1", 1'b0);
  endtask

  task automatic t_lookahead_plain;   // R2
    stim[0] = 2'b00; stim[1] = 2'b10; stim[2] = 2'b10; stim[3] = 2'b11;
    stim[4] = 2'b00; stim[5] = 2'b11;
    stim_n = 6;
    run_main("R2", 1'b0);
  endtask

  task automatic t_substitutions;   // R3
    stim[0] = 2'b00; stim[1] = 2'b00; stim[2] = 2'b00; stim[3] = 2'b01;
    stim[4] = 2'b10; stim[5] = 2'b00; stim[6] = 2'b10; stim[7] = 2'b01;
    stim[8] = 2'b11;
    stim_n = 9;
    run_main("R3", 1'b0);
  endtask

  task automatic t_record_ends;   // R4
    stim[0] = 2'b11; stim[1] = 2'b00; stim_n = 2;
    run_main("R4", 1'b0);
    stim[0] = 2'b10; stim_n = 1;
    run_main("R4", 1'b0);
    stim[0] = 2'b00; stim[1] = 2'b11; stim[2] = 2'b01; stim_n = 3;
    run_main("R4", 1'b0);
  endtask

  task automatic t_zero_run;   // R6
    for (int i = 0; i < 9; i++) stim[i] = 2'b00;
    stim_n = 9;
    run_main("R6", 1'b1);
    stim[0] = 2'b10; stim[1] = 2'b01; stim[2] = 2'b10; stim[3] = 2'b01;
    stim[4] = 2'b10; stim[5] = 2'b11; stim_n = 6;
    run_main("R6", 1'b0);
  endtask

  task automatic t_stream_stall;   // R7
    for (int i = 0; i < 40; i++) stim[i] = 2'($urandom_range(0, 3));
    stim_n = 40;
    run_main("R7", 1'b1);
  endtask

  task automatic t_serial;   // R10
    logic sb [0:4];
    sb[0] = 1'b1; sb[1] = 1'b0; sb[2] = 1'b0; sb[3] = 1'b1; sb[4] = 1'b1;
    cap_n = 0; got_last = 1'b0; last_at = -1; sel_ser = 1'b1;
    for (int i = 0; i < 5; i++) send_bit(sb[i], i == 4);
    while (!got_last) @(negedge clk);
    repeat (2) @(negedge clk);
    stim[0] = 2'b10; stim[1] = 2'b01; stim[2] = 2'b10; stim_n = 3;
    check_record("R10");
    sel_ser = 1'b0;
  endtask

  initial begin
    t_reset();
    t_plain_words();
    t_lookahead_plain();
    t_substitutions();
    t_record_ends();
    t_zero_run();
    t_stream_stall();
    t_serial();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule